// File: doc/BRIEF.md
# Write-Completion Status Poll Logic

This block produces the byte a host sees on the read path of a nonvolatile memory while the memory is busy programming. A write controller supplies a busy flag, the address of the last byte it accepted and that byte's value. While busy is high, every read returns a status byte instead of array contents. Bit 7 of that byte is the inverse of the bit 7 that was written when the host reads back the last written address. Bit 6 flips once for every new read. When busy drops, reads pass the array's own data through unchanged.

The host can therefore detect the end of a programming cycle in either of two ways. It can re-read the last written address until bit 7 matches the value it wrote. It can also pulse output enable or chip enable until bit 6 stops changing.

The read output is registered, so it shows the inputs from one clock earlier. A three-state control FSM tracks whether a read is in progress during a busy period. `ST_IDLE` means no programming is running. `ST_ARMED` means busy with no read in progress. `ST_HELD` means busy with a read in progress. The FSM moves through these states as follows:

- `ST_IDLE` goes to `ST_ARMED` when busy rises with no read active.
- `ST_IDLE` goes to `ST_HELD` when busy rises while a read is already active. This transition does not count as a read.
- `ST_ARMED` goes to `ST_HELD` when a read starts. This is the transition that flips the toggle.
- `ST_HELD` goes back to `ST_ARMED` when the read ends.
- Either busy state returns to `ST_IDLE` when busy falls.

Top module: `wr_status_poll`

## Requirements
- R1: `dout_en` is high in the cycle after a clock edge that samples `ce_n`=0, `oe_n`=0 and `we_n`=1. It is low after any edge that samples any other combination.
- R2: Whenever `dout_en` is low, `dout` is all zeros.
- R3: During a busy read whose `rd_addr` equals `last_addr`, bit 7 of `dout` is the complement of bit 7 of `last_data`.
- R4: Bit 6 of `dout` during busy reads starts at 1 for the first read of a busy period and inverts on every later read start. Reading or holding a read does not change it otherwise.
- R5: A read start is a move from read-inactive to read-active at a clock edge. Raising and lowering either `oe_n` or `ce_n` produces one. Keeping a read active for many cycles counts as a single read.
- R6: During a busy read, bits 5 to 0 of `dout` equal those of `last_data`. Bit 7 equals `last_data` bit 7 when `rd_addr` differs from `last_addr`.
- R7: While busy is low, a read returns `array_data` unchanged on all bits. This holds from the first cycle after busy falls, including in the middle of a held read.
- R8: Each new busy period restarts the toggle, so that period's first read again shows bit 6 = 1.
- R9: A read that is already active when busy rises is not counted. It shows bit 6 = 0 until the next read start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | 13 | Read address |
| array_data | input | 8 | Stored byte at `rd_addr` from the array |
| busy | input | 1 | Programming cycle in progress |
| last_addr | input | 13 | Address of the last byte written |
| last_data | input | 8 | Value of the last byte written |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
The hardest cases are the ones where busy and the read strobes change close together. These are a read that is already held when busy rises, and busy falling in the middle of a held read. The directed tasks set up busy one cycle before, one cycle after, and exactly while a read is asserted. Each task then checks bit 6 and the passthrough on the first cycle after the change. Separate tasks count toggles produced by output-enable pulses and by chip-enable pulses, and confirm that a long held read produces no extra flips.

// File: rtl/wr_status_poll_pkg.sv
package wr_status_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } poll_state_t;
endpackage

// File: rtl/poll_decode.sv
module poll_decode #(
    parameter int AW = 13
) (
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] last_addr,
    output logic          rd_act,
    output logic          addr_hit
);
    always_comb begin
        rd_act   = !ce_n && !oe_n && we_n;
        addr_hit = (rd_addr == last_addr);
    end
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
    import wr_status_poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_act,
    output logic tgl,
    output logic flip
);
    poll_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        flip     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (busy) state_nx = rd_act ? ST_HELD : ST_ARMED;
            end
            ST_ARMED: begin
                if (!busy) state_nx = ST_IDLE;
                else if (rd_act) begin
                    state_nx = ST_HELD;
                    flip     = 1'b1;
                end
            end
            ST_HELD: begin
                if (!busy)       state_nx = ST_IDLE;
                else if (!rd_act) state_nx = ST_ARMED;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tgl <= 1'b0;
        else if (!busy) tgl <= 1'b0;
        else if (flip)  tgl <= ~tgl;
    end

    AST_TGL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (tgl == 1'b0)); // R8
    AST_TGL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(state == ST_ARMED && rd_act)) |=> $stable(tgl)); // R5
endmodule

// File: rtl/poll_mux.sv
module poll_mux #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          busy,
    input  logic          addr_hit,
    input  logic          tgl,
    input  logic          flip,
    input  logic [DW-1:0] last_data,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    localparam int POLL_BIT = DW - 1;
    localparam int TGL_BIT  = DW - 2;

    logic [DW-1:0] stat;

    always_comb begin
        stat           = last_data;
        stat[POLL_BIT] = addr_hit ? ~last_data[POLL_BIT] : last_data[POLL_BIT];
        stat[TGL_BIT]  = flip ? ~tgl : tgl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= rd_act;
            if (!rd_act)   dout <= '0;
            else if (busy) dout <= stat;
            else           dout <= array_data;
        end
    end

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R2
endmodule

// File: rtl/wr_status_poll.sv
module wr_status_poll #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] array_data,
    input  logic          busy,
    input  logic [AW-1:0] last_addr,
    input  logic [DW-1:0] last_data,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    logic rd_act, addr_hit, tgl, flip;

    poll_decode #(.AW(AW)) u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_addr(rd_addr), .last_addr(last_addr),
        .rd_act(rd_act), .addr_hit(addr_hit)
    );

    poll_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .busy(busy), .rd_act(rd_act),
        .tgl(tgl), .flip(flip)
    );

    poll_mux #(.DW(DW)) u_mux (
        .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .busy(busy),
        .addr_hit(addr_hit), .tgl(tgl), .flip(flip),
        .last_data(last_data), .array_data(array_data),
        .dout(dout), .dout_en(dout_en)
    );

    AST_EN_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_en); // R1
    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !oe_n && we_n) |=> !dout_en); // R1
    AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce_n && !oe_n && we_n && rd_addr == last_addr)
        |=> (dout[DW-1] == ~$past(last_data[DW-1]))); // R3
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ce_n && !oe_n && we_n) |=> (dout == $past(array_data))); // R7
endmodule

// File: tb/wr_status_poll_tb.sv
module wr_status_poll_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] rd_addr = '0;
    logic [7:0]  array_data;
    logic        busy = 1'b0;
    logic [12:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    logic [7:0]  dout;
    logic        dout_en;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    assign array_data = rd_addr[7:0] ^ 8'h3C;

    wr_status_poll u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_addr(rd_addr), .array_data(array_data), .busy(busy),
        .last_addr(last_addr), .last_data(last_data),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd_on(input logic [12:0] a);
        rd_addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; step();
    endtask

    task automatic rd_off();
        oe_n = 1'b1; step();
    endtask

    function automatic logic [7:0] stat(input logic hit, input logic t);
        return {hit ? ~last_data[7] : last_data[7], t, last_data[5:0]};
    endfunction

    task automatic t_reset();
        chk("R1 reset en", {7'd0, dout_en}, 8'h00);
        chk("R2 reset dout", dout, 8'h00);
    endtask

    task automatic t_idle();
        rd_on(13'h0123);
        chk("R1 en on read", {7'd0, dout_en}, 8'h01);
        chk("R7 idle data", dout, 8'h23 ^ 8'h3C);
        rd_addr = 13'h0A5; step();
        chk("R7 idle data addr change", dout, 8'hA5 ^ 8'h3C);
        we_n = 1'b0; step();
        chk("R1 we low no drive", {7'd0, dout_en}, 8'h00);
        chk("R2 zero when off", dout, 8'h00);
        we_n = 1'b1; ce_n = 1'b1; step();
        chk("R1 ce high no drive", {7'd0, dout_en}, 8'h00);
        oe_n = 1'b1; step();
    endtask

    task automatic t_oe_toggle();
        last_addr = 13'h1555; last_data = 8'hA7;
        busy = 1'b1; step();
        rd_on(13'h1555);
        chk("R3 poll bit inverted", dout, stat(1'b1, 1'b1));
        chk("R4 first read bit6", {7'd0, dout[6]}, 8'h01);
        step(); step();
        chk("R5 held read no flip", {7'd0, dout[6]}, 8'h01);
        rd_off();
        chk("R2 off between reads", dout, 8'h00);
        rd_on(13'h1555);
        chk("R4 second read", dout, stat(1'b1, 1'b0));
        rd_off(); rd_on(13'h1555);
        chk("R4 third read", dout, stat(1'b1, 1'b1));
        rd_off(); rd_on(13'h0042);
        chk("R6 other addr status", dout, stat(1'b0, 1'b0));
        rd_off();
    endtask

    task automatic t_ce_toggle();
        rd_on(13'h1555);
        chk("R5 oe read before ce", {7'd0, dout[6]}, 8'h01);
        for (int i = 0; i < 3; i++) begin
            ce_n = 1'b1; step();
            ce_n = 1'b0; step();
            chk("R5 ce pulse read", {7'd0, dout[6]}, {7'd0, ~i[0]} ^ 8'h01);
        end
        busy = 1'b0; step();
        chk("R7 busy falls mid read", dout, 8'h55 ^ 8'h3C);
        rd_off();
    endtask

    task automatic t_restart();
        last_addr = 13'h0AAA; last_data = 8'h15;
        busy = 1'b1; step();
        rd_on(13'h0AAA);
        chk("R8 restart bit6", dout, stat(1'b1, 1'b1));
        rd_off(); busy = 1'b0; step();
        rd_on(13'h0AAA);
        busy = 1'b1; step();
        chk("R9 preheld read not counted", dout, stat(1'b1, 1'b0));
        rd_off(); rd_on(13'h0AAA);
        chk("R9 next read counted", dout, stat(1'b1, 1'b1));
        rd_off(); busy = 1'b0; step();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1; step();
                t_idle();
                t_oe_toggle();
                t_ce_toggle();
                t_restart();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule